// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner with Stuck-Low Watchdogs

This block sits between the raw clock and data pins of a two-wire serial bus and the protocol logic behind them. Each raw line first crosses into the core clock domain through a two-stage synchronizer. A per-line deglitcher then holds its output until the synchronized input has kept a new level for more cycles than a programmable spike limit, so narrow noise pulses never reach the protocol logic. A speed-select input picks between two 8-bit limits: one for the standard and fast bus speeds, one for the high-speed bus mode.

Behind each deglitcher a watchdog counts consecutive core cycles in which the filtered line is low. When the count reaches that line's 32-bit timeout, a sticky flag is raised. The data-line flag also produces a recovery request that stays active while the filtered data line is still low, so that a separate sequencer can clock the bus free. One clear strobe drops both flags. A timeout of zero turns the matching watchdog off.

Top module: `i2c_line_conditioner`

## Requirements
- R1: Synchronous reset drives both filtered outputs to 1 and both stuck flags and the recovery request to 0.
- R2: With `hs_sel`=0, a raw low pulse lasting `spike_std` cycles or fewer leaves the filtered output unchanged.
- R3: A raw level that holds for `limit`+1 or more cycles appears on the filtered output exactly `limit`+3 clock edges after the first edge that samples it (two synchronizer stages plus `limit`+1 filter cycles).
- R4: With `hs_sel`=1, `spike_hs` replaces `spike_std` as the limit; with `hs_sel`=0, `spike_std` is used.
- R5: `scl_stuck` rises once filtered SCL has been low for `scl_tmo` consecutive cycles, which is `limit`+3+`scl_tmo` edges after raw SCL falls; a high level on the filtered line restarts the count from zero.
- R6: `sda_stuck` follows the same rule with `sda_tmo`; `sda_recover_req` is 1 exactly while `sda_stuck` is 1 and filtered SDA is 0.
- R7: A timeout of zero keeps the matching stuck flag at 0 however long the line stays low.
- R8: Both stuck flags are sticky and stay set after the line goes high; `stuck_clr`=1 at an edge clears both; if the line is still low past its timeout, the flag sets again at the following edge.
- R9: A limit of 0 passes even a single-cycle raw pulse, 3 edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Raw clock line from the pin |
| sda_raw | input | 1 | Raw data line from the pin |
| hs_sel | input | 1 | 1 selects the high-speed spike limit |
| spike_std | input | 8 | Spike limit for standard/fast speed, in core cycles |
| spike_hs | input | 8 | Spike limit for high speed, in core cycles |
| scl_tmo | input | 32 | Clock-line stuck-low timeout in core cycles, 0 disables |
| sda_tmo | input | 32 | Data-line stuck-low timeout in core cycles, 0 disables |
| stuck_clr | input | 1 | Clear strobe for both stuck flags |
| scl_filt | output | 1 | Filtered clock line |
| sda_filt | output | 1 | Filtered data line |
| scl_stuck | output | 1 | Sticky clock-line stuck-low flag |
| sda_stuck | output | 1 | Sticky data-line stuck-low flag |
| sda_recover_req | output | 1 | Request to run bus recovery on the data line |

## Verification
A raw edge reaches a filtered output `limit`+3 edges after the first edge that samples it. A stuck flag follows `timeout` edges later, a clear strobe takes effect at the next edge, and the recovery request follows the flag and the filtered data line without further delay. The directed cases count edges from the stimulus to the output change and compare that count with these formulas. The random phases run a cycle model that delays its filtered value by the two synchronizer stages and feeds the watchdog model from that delayed value, and they compare every output at the falling edge, half a cycle after the outputs update. Limits and timeouts change only while both lines have been idle high for long enough that no count is in progress, so the cycle alignment holds.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    localparam int LIM_W_DEF  = 8;
    localparam int TMO_W_DEF  = 32;
    localparam int N_LINES    = 2;

    // bit positions inside the packed pin pair below
    localparam int IDX_SCL    = 1;
    localparam int IDX_SDA    = 0;

    typedef enum logic {
        SPD_STD_FAST = 1'b0,
        SPD_HIGH     = 1'b1
    } spd_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } pin_pair_t;

    function automatic logic [LIM_W_DEF-1:0] pick_limit(
        input spd_e                 spd,
        input logic [LIM_W_DEF-1:0] lim_std,
        input logic [LIM_W_DEF-1:0] lim_hs
    );
        return (spd == SPD_HIGH) ? lim_hs : lim_std;
    endfunction

endpackage

// File: rtl/i2cf_sync2.sv
module i2cf_sync2 #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/i2cf_deglitch.sv
module i2cf_deglitch #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [LIM_W-1:0] limit,
    output logic             dout
);
    logic [LIM_W-1:0] run;
    logic             differ;

    assign differ = (din != dout);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b1;
            run  <= '0;
        end else if (!differ) begin
            run  <= '0;
        end else if (run >= limit) begin
            dout <= din;
            run  <= '0;
        end else begin
            run  <= run + LIM_W'(1);
        end
    end

    // R2
    filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> ($past(din) == dout));

    // R9
    filt_pass0_chk: assert property (@(posedge clk) disable iff (rst)
        (limit == '0 && din != dout) |=> (dout == $past(din)));

endmodule

// File: rtl/i2cf_low_watch.sv
module i2cf_low_watch #(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line,
    input  logic [TMO_W-1:0] tmo,
    input  logic             clr,
    output logic             stuck
);
    logic [TMO_W-1:0] low_cnt;
    logic             armed;
    logic             expire;

    assign armed  = (tmo != '0);
    assign expire = armed && !line &&
                    (({1'b0, low_cnt} + (TMO_W+1)'(1)) >= {1'b0, tmo});

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (!armed || line) begin
            low_cnt <= '0;
        end else if (low_cnt < tmo) begin
            low_cnt <= low_cnt + TMO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         stuck <= 1'b0;
        else if (clr)    stuck <= 1'b0;
        else if (expire) stuck <= 1'b1;
    end

    // R5
    stuck_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stuck) |-> !$past(line));

    // R8
    stuck_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !stuck);

    // R7
    tmo_off_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo == '0 && !stuck) |=> !stuck);

endmodule

// File: rtl/i2c_line_conditioner.sv
module i2c_line_conditioner
    import i2cf_pkg::*;
#(
    parameter int LIM_W = LIM_W_DEF,
    parameter int TMO_W = TMO_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_raw,
    input  logic             sda_raw,
    input  logic             hs_sel,
    input  logic [LIM_W-1:0] spike_std,
    input  logic [LIM_W-1:0] spike_hs,
    input  logic [TMO_W-1:0] scl_tmo,
    input  logic [TMO_W-1:0] sda_tmo,
    input  logic             stuck_clr,
    output logic             scl_filt,
    output logic             sda_filt,
    output logic             scl_stuck,
    output logic             sda_stuck,
    output logic             sda_recover_req
);
    pin_pair_t          raw_p;
    pin_pair_t          sync_p;
    logic [N_LINES-1:0] sync_v;
    logic [N_LINES-1:0] filt_v;
    logic [N_LINES-1:0] stuck_v;
    logic [LIM_W-1:0]   limit;
    logic [TMO_W-1:0]   tmo_v [N_LINES];

    assign raw_p.scl = scl_raw;
    assign raw_p.sda = sda_raw;
    assign limit     = (spd_e'(hs_sel) == SPD_HIGH) ? spike_hs : spike_std;

    assign tmo_v[IDX_SCL] = scl_tmo;
    assign tmo_v[IDX_SDA] = sda_tmo;

    i2cf_sync2 #(
        .W       (N_LINES),
        .RST_VAL ({N_LINES{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_p),
        .q   (sync_p)
    );

    assign sync_v = sync_p;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        i2cf_deglitch #(.LIM_W(LIM_W)) u_dg (
            .clk   (clk),
            .rst   (rst),
            .din   (sync_v[i]),
            .limit (limit),
            .dout  (filt_v[i])
        );
        i2cf_low_watch #(.TMO_W(TMO_W)) u_wd (
            .clk   (clk),
            .rst   (rst),
            .line  (filt_v[i]),
            .tmo   (tmo_v[i]),
            .clr   (stuck_clr),
            .stuck (stuck_v[i])
        );
    end

    assign scl_filt        = filt_v[IDX_SCL];
    assign sda_filt        = filt_v[IDX_SDA];
    assign scl_stuck       = stuck_v[IDX_SCL];
    assign sda_stuck       = stuck_v[IDX_SDA];
    assign sda_recover_req = stuck_v[IDX_SDA] & ~filt_v[IDX_SDA];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (scl_filt && sda_filt && !scl_stuck && !sda_stuck));

endmodule

// File: tb/sim_i2c_line_conditioner.sv
module sim_i2c_line_conditioner;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_raw = 1'b1, sda_raw = 1'b1, hs_sel = 1'b0, stuck_clr = 1'b0;
    logic [7:0]  spike_std = 8'd0, spike_hs = 8'd0;
    logic [31:0] scl_tmo = 32'd0, sda_tmo = 32'd0;
    logic        scl_filt, sda_filt, scl_stuck, sda_stuck, sda_recover_req;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit cmp_en = 0;

    always #(CLK_NS/2) clk = ~clk;

    i2c_line_conditioner u0 (
        .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .hs_sel(hs_sel), .spike_std(spike_std), .spike_hs(spike_hs),
        .scl_tmo(scl_tmo), .sda_tmo(sda_tmo), .stuck_clr(stuck_clr),
        .scl_filt(scl_filt), .sda_filt(sda_filt), .scl_stuck(scl_stuck),
        .sda_stuck(sda_stuck), .sda_recover_req(sda_recover_req)
    );

    function automatic int filt_latency(int lim);
        return lim + 3;
    endfunction

    function automatic int stuck_latency(int lim, int tmo);
        return lim + 3 + tmo;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- cycle model (index 0 = SCL, 1 = SDA) ----------------
    logic   m_rv [2];
    int     m_rl [2];
    logic   m_p0 [2], m_p1 [2], m_p2 [2];
    longint m_lr [2];
    logic   m_fl [2];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_rv[i] = 1'b1; m_rl[i] = 0;
                m_p0[i] = 1'b1; m_p1[i] = 1'b1; m_p2[i] = 1'b1;
                m_lr[i] = 0;    m_fl[i] = 1'b0;
            end
        end else begin
            int lim;
            lim = hs_sel ? int'(spike_hs) : int'(spike_std);
            for (int i = 0; i < 2; i++) begin
                logic   raw;
                longint tmo;
                raw = (i == 0) ? scl_raw : sda_raw;
                tmo = (i == 0) ? longint'(scl_tmo) : longint'(sda_tmo);
                if (tmo == 0 || m_p2[i]) m_lr[i] = 0;
                else                     m_lr[i] = m_lr[i] + 1;
                if (stuck_clr)                               m_fl[i] = 1'b0;
                else if (tmo != 0 && !m_p2[i] && m_lr[i] >= tmo) m_fl[i] = 1'b1;
                if (raw == m_rv[i]) begin
                    if (m_rl[i] < 1000) m_rl[i]++;
                end else begin
                    m_rv[i] = raw;
                    m_rl[i] = 1;
                end
                m_p2[i] = m_p1[i];
                m_p1[i] = m_p0[i];
                if (m_rl[i] >= lim + 1 && m_rv[i] != m_p0[i]) m_p0[i] = m_rv[i];
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check("R3", "random scl_filt",  scl_filt,  m_p2[0]);
            check("R3", "random sda_filt",  sda_filt,  m_p2[1]);
            check("R5", "random scl_stuck", scl_stuck, m_fl[0]);
            check("R6", "random sda_stuck", sda_stuck, m_fl[1]);
            check("R6", "random recover",   sda_recover_req, m_fl[1] & ~m_p2[1]);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(int line, logic v);
        if (line == 0) scl_raw = v; else sda_raw = v;
    endtask

    // low pulse of len sampled cycles; returns whether the filtered line dipped
    task automatic pulse_watch(int line, int len, int watch, output bit dipped);
        dipped = 0;
        @(negedge clk);
        drive(line, 1'b0);
        for (int k = 0; k < len + watch; k++) begin
            @(negedge clk);
            if (k == len - 1) drive(line, 1'b1);
            if (((line == 0) ? scl_filt : sda_filt) == 1'b0) dipped = 1;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit dip;
        int n;
        void'($urandom(32'h5eed1c2f));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "scl_filt after reset", scl_filt, 1);
        check("R1", "sda_filt after reset", sda_filt, 1);
        check("R1", "scl_stuck after reset", scl_stuck, 0);
        check("R1", "sda_stuck after reset", sda_stuck, 0);
        check("R1", "recover after reset", sda_recover_req, 0);

        // R2 pulse equal to the limit is removed
        spike_std = 8'd4; spike_hs = 8'd1; hs_sel = 1'b0;
        idle(10);
        pulse_watch(0, 4, 12, dip);
        check("R2", "scl 4-cycle pulse with limit 4 dipped", dip, 0);

        // R3 held level: edge count to output change
        @(negedge clk);
        scl_raw = 1'b0;
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end
        while (scl_filt == 1'b1 && n < 100);
        check("R3", "scl fall latency limit 4", n, filt_latency(4));
        scl_raw = 1'b1;
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end
        while (scl_filt == 1'b0 && n < 100);
        check("R3", "scl rise latency limit 4", n, filt_latency(4));
        idle(10);

        // R4 limit selection
        pulse_watch(1, 2, 12, dip);
        check("R4", "sda 2-cycle pulse std limit 4 dipped", dip, 0);
        hs_sel = 1'b1;
        idle(10);
        pulse_watch(1, 1, 12, dip);
        check("R4", "sda 1-cycle pulse hs limit 1 dipped", dip, 0);
        pulse_watch(1, 2, 12, dip);
        check("R4", "sda 2-cycle pulse hs limit 1 dipped", dip, 1);
        hs_sel = 1'b0;
        idle(10);

        // R9 limit zero
        spike_std = 8'd0;
        idle(10);
        @(negedge clk);
        scl_raw = 1'b0;
        @(negedge clk);
        scl_raw = 1'b1;
        check("R9", "scl after 1 edge", scl_filt, 1);
        @(negedge clk);
        check("R9", "scl after 2 edges", scl_filt, 1);
        @(negedge clk);
        check("R9", "scl after 3 edges", scl_filt, 0);
        @(negedge clk);
        check("R9", "scl after 4 edges", scl_filt, 1);
        idle(10);

        // R5 stuck latency, sticky, restart
        spike_std = 8'd2; scl_tmo = 32'd10;
        idle(10);
        @(negedge clk);
        scl_raw = 1'b0;
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end
        while (scl_stuck == 1'b0 && n < 200);
        check("R5", "scl stuck latency", n, stuck_latency(2, 10));
        scl_raw = 1'b1;
        idle(20);
        check("R8", "scl_stuck sticky after release", scl_stuck, 1);
        stuck_clr = 1'b1;
        @(negedge clk);
        stuck_clr = 1'b0;
        check("R8", "scl_stuck after clear", scl_stuck, 0);
        idle(10);
        scl_raw = 1'b0; idle(8);
        scl_raw = 1'b1; idle(6);
        scl_raw = 1'b0; idle(8);
        scl_raw = 1'b1; idle(20);
        check("R5", "scl_stuck after two short lows", scl_stuck, 0);

        // R6 data line flag and recovery request
        sda_tmo = 32'd5;
        idle(5);
        @(negedge clk);
        sda_raw = 1'b0;
        idle(stuck_latency(2, 5) - 1);
        check("R6", "sda_stuck one edge early", sda_stuck, 0);
        idle(1);
        check("R6", "sda_stuck at latency", sda_stuck, 1);
        check("R6", "recover while low", sda_recover_req, 1);
        // R8 clear while still low re-sets at the next edge
        stuck_clr = 1'b1;
        @(negedge clk);
        stuck_clr = 1'b0;
        check("R8", "sda_stuck right after clear", sda_stuck, 0);
        check("R8", "recover right after clear", sda_recover_req, 0);
        @(negedge clk);
        check("R8", "sda_stuck re-set while low", sda_stuck, 1);
        sda_raw = 1'b1;
        idle(filt_latency(2));
        check("R6", "recover after release", sda_recover_req, 0);
        check("R6", "sda_stuck sticky after release", sda_stuck, 1);
        stuck_clr = 1'b1;
        @(negedge clk);
        stuck_clr = 1'b0;
        idle(10);

        // R7 zero timeout disables
        scl_tmo = 32'd0; sda_tmo = 32'd0;
        idle(5);
        scl_raw = 1'b0; sda_raw = 1'b0;
        idle(150);
        check("R7", "scl_stuck with zero timeout", scl_stuck, 0);
        check("R7", "sda_stuck with zero timeout", sda_stuck, 0);
        check("R7", "recover with zero timeout", sda_recover_req, 0);
        scl_raw = 1'b1; sda_raw = 1'b1;
        idle(20);

        // random phases against the cycle model
        for (int ph = 0; ph < 8; ph++) begin
            int left [2];
            scl_raw = 1'b1; sda_raw = 1'b1; stuck_clr = 1'b0;
            idle(40);
            spike_std = 8'($urandom % 7);
            spike_hs  = 8'($urandom % 7);
            hs_sel    = 1'($urandom % 2);
            scl_tmo   = ($urandom % 4 == 0) ? 32'd0 : 32'(1 + $urandom % 40);
            sda_tmo   = ($urandom % 4 == 0) ? 32'd0 : 32'(1 + $urandom % 40);
            idle(2);
            cmp_en = 1;
            left[0] = 0; left[1] = 0;
            for (int c = 0; c < 1500; c++) begin
                @(negedge clk);
                for (int i = 0; i < 2; i++) begin
                    if (left[i] == 0) begin
                        drive(i, 1'($urandom % 2));
                        left[i] = ($urandom % 5 == 0) ? 1 + int'($urandom % 60)
                                                       : 1 + int'($urandom % 10);
                    end
                    left[i]--;
                end
                stuck_clr = ($urandom % 40 == 0);
            end
            @(negedge clk);
            cmp_en = 0;
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule